// File: doc/BRIEF.md
# Integer Arithmetic Logic Unit with Signed Overflow Flag

This block is a purely combinational 32-bit integer datapath unit. A 4-bit operation code selects one function of two operands. It can add or subtract with or without overflow reporting, apply a bitwise logic function, or compare the operands as signed or unsigned values. Along with the 32-bit result it gives a flag that is high when the result is all zeros, and an overflow flag.

Addition and subtraction use one shared adder. Subtraction inverts the second operand and feeds a carry-in of one. The overflow flag is the XOR of the carry into the sign bit and the carry out of it. It is passed to the output only for the two trapping operations, signed add and signed subtract. The non-trapping add and subtract wrap silently, even when the adder carries out. Immediate extension, multiply, divide and trap handling are done outside this unit.

The unit has no clock and no state. Each operation is a single combinational evaluation, so there is no flow control and no back-pressure: the outputs follow the inputs within the same cycle.

Top module: `int_alu`

## Requirements
- R1: Codes 0010 (signed add) and 0011 (wrapping add) give result = A + B modulo 2^32.
- R2: Codes 0110 (signed subtract) and 0111 (wrapping subtract) give result = A - B modulo 2^32.
- R3: Code 0000 gives A AND B, 0001 gives A OR B, 0100 gives A XOR B, and 0101 gives NOT (A OR B).
- R4: Under code 0010 the overflow flag is high exactly when A and B have the same sign bit (bit 31) and the result's sign bit differs from it.
- R5: Under code 0110 the overflow flag is high exactly when the sign bits of A and B differ and the result's sign bit differs from that of A.
- R6: Under codes 0011 and 0111 the overflow flag stays low, including when the sum carries out of bit 31 or the difference borrows.
- R7: Code 1000 gives result 1 when A is less than B as two's-complement values, and 0 otherwise. This holds even when A - B overflows.
- R8: Code 1001 gives result 1 when A is less than B as unsigned values, and 0 otherwise.
- R9: The zero flag is high exactly when all 32 result bits are 0, whatever the operation.
- R10: Codes 1010 to 1111 give result 0 with the overflow flag low, so the zero flag is high.
- R11: Under the logic and compare codes (0000, 0001, 0100, 0101, 1000, 1001) the overflow flag stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_sel | input | 4 | Operation code |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand |
| result | output | 32 | Operation result |
| zero_flag | output | 1 | High when the result is all zeros |
| ovf_flag | output | 1 | Signed overflow, only for the trapping add and subtract |

## Verification
The add and subtract paths are driven with operand pairs at the sign boundaries, 0x7FFFFFFF, 0x80000000 and 0xFFFFFFFF. These pairs separate the four cases: no carry, carry without overflow, overflow without carry, and both. The same pairs are then run through the wrapping codes, which shows that a carry-out or borrow never reaches the overflow flag. The compare codes use pairs where the signed and unsigned orders disagree, and pairs where A - B overflows, so a sign-only comparison would fail. Logic codes use complementary and alternating bit patterns, and results that are exactly zero exercise the zero flag on several operations.

// File: rtl/int_alu_pkg.sv
package int_alu_pkg;
  localparam int unsigned OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_AND  = 4'b0000,
    OP_OR   = 4'b0001,
    OP_ADD  = 4'b0010,
    OP_ADDW = 4'b0011,
    OP_XOR  = 4'b0100,
    OP_NOR  = 4'b0101,
    OP_SUB  = 4'b0110,
    OP_SUBW = 4'b0111,
    OP_SLT  = 4'b1000,
    OP_SLTU = 4'b1001
  } alu_op_e;

  typedef enum logic [1:0] {
    LG_AND = 2'd0,
    LG_OR  = 2'd1,
    LG_XOR = 2'd2,
    LG_NOR = 2'd3
  } logic_fn_e;
endpackage

// File: rtl/int_alu_adder.sv
// Shared adder / subtractor exposing the carries around the sign bit.
module int_alu_adder #(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             sub,
  output logic [WIDTH-1:0] sum,
  output logic             carry_out,
  output logic             ovf_raw
);
  localparam int unsigned LOW = WIDTH - 1;

  logic [WIDTH-1:0] b_eff;
  logic [LOW-1:0]   sum_low;
  logic             carry_into_msb;
  logic             sum_msb;

  always_comb begin
    b_eff = b ^ {WIDTH{sub}};
    {carry_into_msb, sum_low} = {1'b0, a[LOW-1:0]} + {1'b0, b_eff[LOW-1:0]}
                              + {{LOW{1'b0}}, sub};
    {carry_out, sum_msb} = {1'b0, a[WIDTH-1]} + {1'b0, b_eff[WIDTH-1]}
                         + {1'b0, carry_into_msb};
    sum     = {sum_msb, sum_low};
    ovf_raw = carry_into_msb ^ carry_out;
  end
endmodule

// File: rtl/int_alu_logic.sv
// Bitwise logic functions, one bit slice per generate iteration.
module int_alu_logic
  import int_alu_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic_fn_e        fn,
  output logic [WIDTH-1:0] y
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    always_comb begin
      case (fn)
        LG_AND:  y[i] = a[i] & b[i];
        LG_OR:   y[i] = a[i] | b[i];
        LG_XOR:  y[i] = a[i] ^ b[i];
        default: y[i] = ~(a[i] | b[i]);
      endcase
    end
  end
endmodule

// File: rtl/int_alu_compare.sv
// Less-than decision from the subtractor's sign, overflow and carry.
module int_alu_compare #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             diff_sign,
  input  logic             diff_ovf,
  input  logic             diff_carry,
  input  logic             is_unsigned,
  output logic [WIDTH-1:0] y
);
  logic lt;

  always_comb begin
    lt = is_unsigned ? ~diff_carry : (diff_sign ^ diff_ovf);
    y  = {{(WIDTH-1){1'b0}}, lt};
  end
endmodule

// File: rtl/int_alu.sv
module int_alu
  import int_alu_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic [OP_W-1:0]  op_sel,
  input  logic [WIDTH-1:0] opnd_a,
  input  logic [WIDTH-1:0] opnd_b,
  output logic [WIDTH-1:0] result,
  output logic             zero_flag,
  output logic             ovf_flag
);
  localparam int unsigned MSB = WIDTH - 1;

  alu_op_e          op;
  logic             do_sub;
  logic [WIDTH-1:0] add_sum;
  logic             add_cout;
  logic             add_ovf;
  logic_fn_e        lg_fn;
  logic [WIDTH-1:0] lg_y;
  logic [WIDTH-1:0] cmp_y;
  logic             is_logic;
  logic             is_arith;
  logic             is_cmp;

  always_comb begin
    op       = alu_op_e'(op_sel);
    do_sub   = (op == OP_SUB) || (op == OP_SUBW) || (op == OP_SLT) || (op == OP_SLTU);
    is_arith = (op == OP_ADD) || (op == OP_ADDW) || (op == OP_SUB) || (op == OP_SUBW);
    is_cmp   = (op == OP_SLT) || (op == OP_SLTU);
    is_logic = (op == OP_AND) || (op == OP_OR) || (op == OP_XOR) || (op == OP_NOR);
    case (op)
      OP_AND:  lg_fn = LG_AND;
      OP_OR:   lg_fn = LG_OR;
      OP_XOR:  lg_fn = LG_XOR;
      default: lg_fn = LG_NOR;
    endcase
  end

  int_alu_adder #(.WIDTH(WIDTH)) u_adder (
    .a         (opnd_a),
    .b         (opnd_b),
    .sub       (do_sub),
    .sum       (add_sum),
    .carry_out (add_cout),
    .ovf_raw   (add_ovf)
  );

  int_alu_logic #(.WIDTH(WIDTH)) u_logic (
    .a  (opnd_a),
    .b  (opnd_b),
    .fn (lg_fn),
    .y  (lg_y)
  );

  int_alu_compare #(.WIDTH(WIDTH)) u_cmp (
    .diff_sign   (add_sum[MSB]),
    .diff_ovf    (add_ovf),
    .diff_carry  (add_cout),
    .is_unsigned (op == OP_SLTU),
    .y           (cmp_y)
  );

  always_comb begin
    if (is_arith)      result = add_sum;
    else if (is_logic) result = lg_y;
    else if (is_cmp)   result = cmp_y;
    else               result = '0;
    zero_flag = ~|result;
    ovf_flag  = add_ovf && ((op == OP_ADD) || (op == OP_SUB));
  end
endmodule

// File: rtl/int_alu_chk.sv
module int_alu_chk
  import int_alu_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input logic [OP_W-1:0]  op_sel,
  input logic [WIDTH-1:0] opnd_a,
  input logic [WIDTH-1:0] opnd_b,
  input logic [WIDTH-1:0] result,
  input logic             zero_flag,
  input logic             ovf_flag
);
  localparam int unsigned MSB = WIDTH - 1;

  always_comb begin
    if (op_sel == OP_ADD) begin
      // R4
      add_sign_ovf_chk: assert (ovf_flag == ((opnd_a[MSB] == opnd_b[MSB]) &&
                                             (result[MSB] != opnd_a[MSB])))
        else $error("signed add overflow mismatch");
    end
    if (op_sel == OP_SUB) begin
      // R5
      sub_sign_ovf_chk: assert (ovf_flag == ((opnd_a[MSB] != opnd_b[MSB]) &&
                                             (result[MSB] != opnd_a[MSB])))
        else $error("signed subtract overflow mismatch");
    end
    if (op_sel != OP_ADD && op_sel != OP_SUB) begin
      // R6 R11
      no_overflow_chk: assert (!ovf_flag)
        else $error("overflow raised by non-trapping code");
    end
    // R9
    zero_flag_chk: assert (zero_flag == (result == '0))
      else $error("zero flag mismatch");
    if (op_sel == OP_SLT || op_sel == OP_SLTU) begin
      // R7 R8
      cmp_range_chk: assert (result[MSB:1] == '0)
        else $error("compare result not 0 or 1");
    end
    if (op_sel > OP_SLTU) begin
      // R10
      unused_code_chk: assert (result == '0)
        else $error("unused code gave nonzero result");
    end
  end
endmodule

bind int_alu int_alu_chk #(.WIDTH(WIDTH)) u_chk (
  .op_sel    (op_sel),
  .opnd_a    (opnd_a),
  .opnd_b    (opnd_b),
  .result    (result),
  .zero_flag (zero_flag),
  .ovf_flag  (ovf_flag)
);

// File: tb/int_alu_tb.sv
module int_alu_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  op_sel = 4'b0000;
  logic [31:0] opnd_a = '0;
  logic [31:0] opnd_b = '0;
  logic [31:0] result;
  logic        zero_flag;
  logic        ovf_flag;

  int n_vec = 0;
  int n_bad = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  int_alu u_dut (
    .op_sel    (op_sel),
    .opnd_a    (opnd_a),
    .opnd_b    (opnd_b),
    .result    (result),
    .zero_flag (zero_flag),
    .ovf_flag  (ovf_flag)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 5000 && !done) begin
      done = 1'b1;
      n_bad++;
      $display("FAIL watchdog: actual=%0d cycles expected<=5000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] exp_res,
                       input logic exp_ovf);
    logic exp_zero;
    exp_zero = (exp_res == 32'd0);
    n_vec++;
    if (result !== exp_res || ovf_flag !== exp_ovf || zero_flag !== exp_zero) begin
      n_bad++;
      $display("FAIL %s op=%b a=%h b=%h: actual res=%h ovf=%b z=%b expected res=%h ovf=%b z=%b",
               req, op_sel, opnd_a, opnd_b, result, ovf_flag, zero_flag,
               exp_res, exp_ovf, exp_zero);
    end
  endtask

  task automatic drive(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    op_sel = op;
    opnd_a = a;
    opnd_b = b;
    #2;
  endtask

  task automatic t_reset_state;
    @(negedge clk);
    check("R3 R9 idle", 32'd0, 1'b0);
  endtask

  task automatic t_add;
    logic [32:0] s;
    logic [31:0] a_l [5] = '{32'd5, 32'h7FFFFFFF, 32'h80000000, 32'hFFFFFFFF, 32'hFFFFFFFE};
    logic [31:0] b_l [5] = '{32'd7, 32'd1, 32'h80000000, 32'd1, 32'hFFFFFFFF};
    logic        ov  [5] = '{1'b0, 1'b1, 1'b1, 1'b0, 1'b0};
    for (int i = 0; i < 5; i++) begin
      s = {1'b0, a_l[i]} + {1'b0, b_l[i]};
      drive(4'b0010, a_l[i], b_l[i]);
      check("R1 R4 add", s[31:0], ov[i]);
      drive(4'b0011, a_l[i], b_l[i]);
      check("R1 R6 addw", s[31:0], 1'b0);
    end
  endtask

  task automatic t_sub;
    logic [31:0] a_l [5] = '{32'd9, 32'h80000000, 32'h7FFFFFFF, 32'd3, 32'h12345678};
    logic [31:0] b_l [5] = '{32'd4, 32'd1, 32'hFFFFFFFF, 32'd5, 32'h12345678};
    logic        ov  [5] = '{1'b0, 1'b1, 1'b1, 1'b0, 1'b0};
    for (int i = 0; i < 5; i++) begin
      drive(4'b0110, a_l[i], b_l[i]);
      check("R2 R5 sub", a_l[i] - b_l[i], ov[i]);
      drive(4'b0111, a_l[i], b_l[i]);
      check("R2 R6 subw", a_l[i] - b_l[i], 1'b0);
    end
  endtask

  task automatic t_logic;
    logic [31:0] a_l [3] = '{32'hAAAA5555, 32'hFFFFFFFF, 32'h0F0F00F0};
    logic [31:0] b_l [3] = '{32'h5555AAAA, 32'h00000000, 32'h0FF0F00F};
    for (int i = 0; i < 3; i++) begin
      drive(4'b0000, a_l[i], b_l[i]); check("R3 R11 and", a_l[i] & b_l[i], 1'b0);
      drive(4'b0001, a_l[i], b_l[i]); check("R3 R11 or",  a_l[i] | b_l[i], 1'b0);
      drive(4'b0100, a_l[i], b_l[i]); check("R3 R11 xor", a_l[i] ^ b_l[i], 1'b0);
      drive(4'b0101, a_l[i], b_l[i]); check("R3 R11 nor", ~(a_l[i] | b_l[i]), 1'b0);
    end
  endtask

  task automatic t_compare;
    logic [31:0] a_l [6] = '{32'd3, 32'd7, 32'hFFFFFFFF, 32'h80000000, 32'h7FFFFFFF, 32'd4};
    logic [31:0] b_l [6] = '{32'd7, 32'd3, 32'd1, 32'h7FFFFFFF, 32'h80000000, 32'd4};
    for (int i = 0; i < 6; i++) begin
      drive(4'b1000, a_l[i], b_l[i]);
      check("R7 R11 slt", {31'd0, $signed(a_l[i]) < $signed(b_l[i])}, 1'b0);
      drive(4'b1001, a_l[i], b_l[i]);
      check("R8 R11 sltu", {31'd0, a_l[i] < b_l[i]}, 1'b0);
    end
  endtask

  task automatic t_zero;
    drive(4'b0010, 32'hFFFFFFFF, 32'd1);  check("R9 add wraps to zero", 32'd0, 1'b0);
    drive(4'b0010, 32'h80000000, 32'h80000000); check("R9 R4 zero with ovf", 32'd0, 1'b1);
    drive(4'b0100, 32'hDEADBEEF, 32'hDEADBEEF); check("R9 xor zero", 32'd0, 1'b0);
  endtask

  task automatic t_unused;
    for (int c = 10; c < 16; c++) begin
      drive(4'(c), 32'h7FFFFFFF, 32'h7FFFFFFF);
      check("R10 unused", 32'd0, 1'b0);
    end
  endtask

  initial begin
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    t_reset_state();
    t_add();
    t_sub();
    t_logic();
    t_compare();
    t_zero();
    t_unused();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule